// File: doc/BRIEF.md
# Element Saturation and Width Conversion Unit

This block finishes one vector element after the arithmetic has produced a full-precision intermediate result. It first limits that result to the range of the source element width, using signed clamping, unsigned clamping or plain modulo truncation. It then widens or narrows the limited value to the destination element width. Signed results are sign-extended on the way. All other results are zero-extended.

Each element arrives with a valid strobe. It carries its own source width code, destination width code and 2-bit saturate mode. The converted element leaves one clock later with its own valid strobe. A flag for the reserved mode leaves at the same time. A sticky flag records whether any element of the current operation had to be clamped, so that overflow never wraps silently. The flag is cleared by a separate clear input at the start of each operation.

Top module: `elem_sat_conv`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `out_data`, `sat_flag` and `mode_illegal` are all zero.
- R2: `out_valid` is high exactly one clock after `in_valid`. `out_data` changes only in a cycle that follows an accepted element, and holds its value otherwise.
- R3: A width code selects the element width: 2'b00 = 64 bits (`DATA_W`), 2'b01 = 8, 2'b10 = 16, 2'b11 = 32. The same coding applies to source and destination.
- R4: Saturate mode 2'b10 (signed) reads `in_res` as a two's-complement number. It clamps the number to the range -2^(S-1) through 2^(S-1)-1, where S is the source width.
- R5: Saturate mode 2'b01 (unsigned) clamps the two's-complement `in_res` to the range 0 through 2^S-1, where S is the source width.
- R6: Saturate mode 2'b00 keeps the low S bits of `in_res` without clamping, and never counts as saturation.
- R7: The reserved mode 2'b11 behaves exactly like 2'b00. It also raises `mode_illegal` in the output cycle of that element, and only there.
- R8: In signed mode, the clamped value is sign-extended from bit S-1 up to the destination width D. Bits at D and above are zero. If D < S, the value is cut to its low D bits.
- R9: In modes 2'b00, 2'b01 and 2'b11, the S-bit value is zero-extended to D, and cut to the low D bits if D < S. Bits at D and above are zero.
- R10: `sat_flag` rises after any accepted element that was clamped, and stays high until `sticky_clr`. A clear removes the earlier history, but an element that is clamped in the clearing cycle still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Element strobe |
| in_res | input | RES_W | Full-precision two's-complement result |
| src_wc | input | 2 | Source width code |
| dst_wc | input | 2 | Destination width code |
| sat_mode | input | 2 | Saturate mode |
| sticky_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Converted element strobe |
| out_data | output | DATA_W | Converted element, zero above destination width |
| sat_flag | output | 1 | Sticky clamping indicator |
| mode_illegal | output | 1 | Reserved saturate mode seen on this element |

## Verification
Every result is due one clock after the element that causes it: `out_valid`, `out_data`, `mode_illegal` and the update of `sat_flag` all come from the same register stage. The bench drives each element on a falling edge. At the next falling edge it compares every output with a behavioural model that has already absorbed that element, including a held data value and a modelled sticky flag. Idle cycles and clear-only cycles are compared in the same way, which shows that data holds and that the flag persists or clears as required.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    SM_WRAP = 2'b00,
    SM_UNS  = 2'b01,
    SM_SGN  = 2'b10,
    SM_RSV  = 2'b11
  } sat_mode_t;

  localparam int NUM_WC = 4;
endpackage

// File: rtl/sat_clamp.sv
module sat_clamp
  import sat_pkg::*;
#(
  parameter int RES_W  = 128,
  parameter int DATA_W = 64
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic [1:0]        src_i,
  input  sat_mode_t         mode_i,
  output logic [DATA_W-1:0] val_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] lane_val [NUM_WC];
  logic              lane_hit [NUM_WC];

  // one clamping lane per width code, selected by the source code
  for (genvar k = 0; k < NUM_WC; k++) begin : g_lane
    localparam int W = (k == 0) ? DATA_W : (4 << k);
    localparam logic [RES_W-1:0] ONE  = {{(RES_W-1){1'b0}}, 1'b1};
    localparam logic [RES_W-1:0] SMAX = (ONE << (W-1)) - ONE;
    localparam logic [RES_W-1:0] SMIN = ~SMAX;
    localparam logic [RES_W-1:0] UMAX = (ONE << W) - ONE;

    logic [RES_W-1:0] pick;
    logic             hit;

    always_comb begin
      pick = res_i;
      hit  = 1'b0;
      case (mode_i)
        SM_SGN: begin
          if ($signed(res_i) > $signed(SMAX)) begin
            pick = SMAX;
            hit  = 1'b1;
          end else if ($signed(res_i) < $signed(SMIN)) begin
            pick = SMIN;
            hit  = 1'b1;
          end
        end
        SM_UNS: begin
          if (res_i[RES_W-1]) begin
            pick = '0;
            hit  = 1'b1;
          end else if (res_i > UMAX) begin
            pick = UMAX;
            hit  = 1'b1;
          end
        end
        default: ;
      endcase
    end

    assign lane_val[k] = pick[DATA_W-1:0] & UMAX[DATA_W-1:0];
    assign lane_hit[k] = hit;
  end

  assign val_o = lane_val[src_i];
  assign hit_o = lane_hit[src_i];
endmodule

// File: rtl/width_extend.sv
module width_extend
  import sat_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [1:0]        src_i,
  input  logic [1:0]        dst_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] val_o
);
  logic [DATA_W-1:0] msk [NUM_WC];

  for (genvar k = 0; k < NUM_WC; k++) begin : g_mask
    localparam int W = (k == 0) ? DATA_W : (4 << k);
    localparam logic [DATA_W:0] ONE  = {{DATA_W{1'b0}}, 1'b1};
    localparam logic [DATA_W:0] FULL = (ONE << W) - ONE;
    assign msk[k] = FULL[DATA_W-1:0];
  end

  logic [DATA_W-1:0] src_m;
  logic [DATA_W-1:0] top_bit;
  logic              neg;
  logic [DATA_W-1:0] widened;

  always_comb begin
    src_m   = msk[src_i];
    top_bit = src_m ^ (src_m >> 1);
    neg     = sext_i && ((val_i & top_bit) != '0);
    widened = neg ? (val_i | ~src_m) : val_i;
    val_o   = widened & msk[dst_i];
  end
endmodule

// File: rtl/elem_sat_conv.sv
module elem_sat_conv
  import sat_pkg::*;
#(
  parameter int RES_W  = 128,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [RES_W-1:0]  in_res,
  input  logic [1:0]        src_wc,
  input  logic [1:0]        dst_wc,
  input  logic [1:0]        sat_mode,
  input  logic              sticky_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              sat_flag,
  output logic              mode_illegal
);
  sat_mode_t         mode;
  logic [DATA_W-1:0] clamped;
  logic              clamp_hit;
  logic [DATA_W-1:0] conv;

  assign mode = sat_mode_t'(sat_mode);

  sat_clamp #(.RES_W(RES_W), .DATA_W(DATA_W)) u_clamp (
    .res_i  (in_res),
    .src_i  (src_wc),
    .mode_i (mode),
    .val_o  (clamped),
    .hit_o  (clamp_hit)
  );

  width_extend #(.DATA_W(DATA_W)) u_ext (
    .val_i  (clamped),
    .src_i  (src_wc),
    .dst_i  (dst_wc),
    .sext_i (mode == SM_SGN),
    .val_o  (conv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      sat_flag     <= 1'b0;
      mode_illegal <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      mode_illegal <= in_valid && (mode == SM_RSV);
      if (in_valid) out_data <= conv;
      sat_flag <= (sticky_clr ? 1'b0 : sat_flag) | (in_valid & clamp_hit);
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R2
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sticky_clr) |=> sat_flag); // R10
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sticky_clr && !(in_valid && clamp_hit)) |=> !sat_flag); // R10
  AST_RSV_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_mode == 2'b11) |=> mode_illegal); // R7
  AST_WRAP_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_mode[0] && !sat_mode[1]) |-> !clamp_hit); // R6
endmodule

// File: tb/tb_elem_sat_conv.sv
`timescale 1ns/1ps
module tb_elem_sat_conv;
  localparam int RES_W  = 128;
  localparam int DATA_W = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [RES_W-1:0]  in_res = '0;
  logic [1:0]        src_wc = '0, dst_wc = '0, sat_mode = '0;
  logic              sticky_clr = 1'b0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              sat_flag;
  logic              mode_illegal;

  elem_sat_conv #(.RES_W(RES_W), .DATA_W(DATA_W)) dut (.*);

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // model state: expected outputs at the next falling edge
  bit           have_exp = 0;
  string        exp_tag;
  bit           e_valid = 0, e_ill = 0, e_sat = 0;
  logic [63:0]  e_data = '0;

  function automatic int wbits(input logic [1:0] c);
    case (c)
      2'd1: return 8;
      2'd2: return 16;
      2'd3: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic model(input logic [127:0] r, input logic [1:0] s, d, m,
                       output logic [63:0] dat, output bit c);
    int sw, dw;
    logic signed [127:0] rv, v, hi, lo, umax;
    logic [127:0] dm;
    sw = wbits(s);
    dw = wbits(d);
    rv = r;
    v  = rv;
    c  = 0;
    umax = (128'sd1 <<< sw) - 1;
    if (m == 2'b10) begin
      hi = (128'sd1 <<< (sw - 1)) - 1;
      lo = -hi - 1;
      if (rv > hi) begin v = hi; c = 1; end
      else if (rv < lo) begin v = lo; c = 1; end
    end else begin
      if (m == 2'b01) begin
        if (rv < 0) begin v = 0; c = 1; end
        else if (rv > umax) begin v = umax; c = 1; end
      end
      v = v & umax;
    end
    dm  = (128'd1 << dw) - 1;
    dat = 64'(v & dm);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    if (have_exp) begin
      chk(exp_tag, "out_valid (R2)", 64'(out_valid), 64'(e_valid));
      chk(exp_tag, "out_data", out_data, e_data);
      chk(exp_tag, "mode_illegal (R7)", 64'(mode_illegal), 64'(e_ill));
      chk(exp_tag, "sat_flag (R10)", 64'(sat_flag), 64'(e_sat));
    end
  endtask

  task automatic step(input string tag, input logic [127:0] r,
                      input logic [1:0] s, d, m, input bit v, input bit clr);
    logic [63:0] dat;
    bit c;
    @(negedge clk);
    compare_now();
    model(r, s, d, m, dat, c);
    e_valid = v;
    e_ill   = v && (m == 2'b11);
    if (v) e_data = dat;
    e_sat   = (clr ? 1'b0 : e_sat) | (v & c);
    exp_tag = tag;
    have_exp = 1;
    in_valid = v; in_res = r; src_wc = s; dst_wc = d;
    sat_mode = m; sticky_clr = clr;
  endtask

  function automatic logic [127:0] sx(input longint x);
    return {{64{x[63]}}, x};
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "out_data", out_data, 64'd0);
    chk("R1", "sat_flag", 64'(sat_flag), 64'd0);
    chk("R1", "mode_illegal", 64'(mode_illegal), 64'd0);

    // R4 signed clamps at source width, R8 sign extension
    step("R4 pos clamp s8", sx(200), 2'd1, 2'd1, 2'b10, 1, 0);
    step("R4 neg clamp s8 d32 R8", sx(-300), 2'd1, 2'd3, 2'b10, 1, 1);
    step("R4 in range s8 d64 R8", sx(-5), 2'd1, 2'd0, 2'b10, 1, 1);
    step("R8 narrow dest s32 d8", sx(-2), 2'd3, 2'd1, 2'b10, 1, 0);
    step("R3 R4 s64 clamp", 128'd1 << 70, 2'd0, 2'd0, 2'b10, 1, 1);
    step("R3 R4 s16 neg clamp", sx(-40000), 2'd2, 2'd0, 2'b10, 1, 1);
    // R5 unsigned
    step("R5 over s8", sx(300), 2'd1, 2'd2, 2'b01, 1, 1);
    step("R5 negative", sx(-1), 2'd1, 2'd0, 2'b01, 1, 1);
    step("R5 in range R9", sx(100), 2'd1, 2'd0, 2'b01, 1, 1);
    step("R3 R5 s64 over", 128'd1 << 64, 2'd0, 2'd0, 2'b01, 1, 1);
    // R6 wrap, R9 zero extension
    step("R6 wrap s8 d16 R9", sx(32'h1FF), 2'd1, 2'd2, 2'b00, 1, 1);
    step("R6 wrap neg s16 d64 R9", sx(-1), 2'd2, 2'd0, 2'b00, 1, 0);
    // R7 reserved
    step("R7 reserved", sx(32'h1234), 2'd1, 2'd3, 2'b11, 1, 0);
    // R2 idle hold, R10 sticky
    step("R2 idle hold", sx(999), 2'd1, 2'd1, 2'b10, 0, 0);
    step("R10 set", sx(1000), 2'd1, 2'd1, 2'b10, 1, 0);
    step("R10 keep no-clamp", sx(3), 2'd1, 2'd1, 2'b10, 1, 0);
    step("R10 keep idle", sx(0), 2'd0, 2'd0, 2'b00, 0, 0);
    step("R10 clear alone", sx(0), 2'd0, 2'd0, 2'b00, 0, 1);
    step("R10 clear plus clamp", sx(-999), 2'd1, 2'd1, 2'b10, 1, 1);
    step("R10 after", sx(0), 2'd0, 2'd0, 2'b00, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [127:0] r;
      r = {$urandom, $urandom, $urandom, $urandom};
      r = 128'($signed(r) >>> $urandom_range(0, 127));
      step("R3/R4/R5/R6/R8/R9 random", r, 2'($urandom), 2'($urandom),
           2'($urandom), ($urandom_range(0, 3) != 0), ($urandom_range(0, 15) == 0));
    end
    step("flush", '0, 2'd0, 2'd0, 2'b00, 0, 0);
    @(negedge clk);
    compare_now();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule